// File: doc/BRIEF.md
# Dual-Direction Inter-Processor Mailbox

This block lets an application processor (side A) and a microcontroller (side B) pass short command messages to each other through a shared register file. Each side reaches the block through its own simple APB-style register port: a select, an enable for the access phase, a write strobe, an address and the write and read data. Every access completes in its access phase and there is no wait state. The block has no streaming data path, so it has no valid/ready interface. All of its pins are plain control and status pins.

Messages travel in two directions, A to B and B to A. Each direction has four channels, and each channel has a command word and a data word. The sender writes the command word first and the data word second. The data write rings the doorbell: it sets the channel's pending bit in that direction's status register. The receiver sees a level-sensitive, active-high interrupt for each channel whenever that channel is pending and enabled. The receiver clears a pending bit by writing a one to it. A small bank of hardware locks lets the two processors arbitrate for shared resources. Reading a lock tests it and takes it in the same access, and any write to a lock releases it.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every enable, status, command, data and lock register reads 0, and both interrupt vectors are 0.
- R2: The address map is fixed.
  - A-to-B registers: enable at 0x00, status at 0x04, command of channel x at 0x08+8x, data of channel x at 0x0C+8x.
  - B-to-A registers: enable at 0x28, status at 0x2C, command of channel x at 0x30+8x, data of channel x at 0x34+8x.
  - Lock x sits at 0x100+8x.
  - Either port can read every command and data word, and each word holds its value until its sender overwrites it.
- R3: When the sender writes the data word of channel x, status bit x of that direction is set. A write to the command word leaves the status unchanged.
- R4: The receiver clears status bits by writing to the status register. Each bit written as 1 clears that bit, and each bit written as 0 leaves it unchanged. If a doorbell and a clear of the same bit arrive in the same cycle, the bit stays set.
- R5: Interrupt bit x toward the receiver is high exactly while status bit x and enable bit x of that direction are both 1. The receiver writes the low 4 bits of the enable register, and bit x gates channel x.
- R6: Each port may write only what it owns, and a port's writes to registers it does not own have no effect.
  - Side A owns the A-to-B command and data words and the B-to-A enable and status registers.
  - Side B owns the B-to-A command and data words and the A-to-B enable and status registers.
- R7: A read of a free lock returns 0 and takes the lock. A read of a held lock returns 1. A write of any value from either side frees the lock.
- R8: In the same cycle, requests to one lock resolve as follows.
  - If both ports read a free lock, side A gets 0 and side B gets 1.
  - If one port reads a free lock while the other writes it, the lock ends up held.
  - If one port reads a held lock while the other writes it, the reader gets 1 and the lock ends up free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A select |
| a_enable | input | 1 | Side A access phase; the access takes effect in this cycle |
| a_write | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 12 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid during the access phase |
| b_sel | input | 1 | Side B select |
| b_enable | input | 1 | Side B access phase |
| b_write | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 12 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid during the access phase |
| irq_to_a | output | 4 | Per-channel interrupts toward side A (B-to-A direction) |
| irq_to_b | output | 4 | Per-channel interrupts toward side B (A-to-B direction) |

## Verification
The hardest cases to reach are the same-cycle collisions: two test-and-set reads of one free lock, a release meeting a read, and a doorbell meeting a write-one-to-clear of the same bit. A serial register driver can never produce these. The bench therefore drives both ports through a single access task that places the access phases of both sides in the same clock cycle. It then reads the resulting state back through the ordinary ports, and reads each port's data in that same access phase.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [31:0] A2B_BASE  = 32'h000;
  localparam logic [31:0] B2A_BASE  = 32'h028;
  localparam logic [31:0] LOCK_BASE = 32'h100;
  localparam int          STRIDE    = 8;
  localparam logic [31:0] OFF_EN    = 32'h0;
  localparam logic [31:0] OFF_ST    = 32'h4;
  localparam logic [31:0] OFF_CMD   = 32'h8;
  localparam logic [31:0] OFF_DAT   = 32'hC;
endpackage

// File: rtl/mbx_dir.sv
module mbx_dir #(
  parameter int NCHAN = 4,
  parameter int DW    = 32,
  parameter int AW    = 12,
  parameter logic [31:0] BASE = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snd_wr,
  input  logic [AW-1:0]    snd_addr,
  input  logic [DW-1:0]    snd_wdata,
  input  logic             rcv_wr,
  input  logic [AW-1:0]    rcv_addr,
  input  logic [DW-1:0]    rcv_wdata,
  input  logic [AW-1:0]    rd_addr_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [DW-1:0]    rdata_a,
  output logic [DW-1:0]    rdata_b,
  output logic [NCHAN-1:0] irq
);
  import mbx_pkg::*;
  localparam logic [AW-1:0] EN_ADDR = AW'(BASE + OFF_EN);
  localparam logic [AW-1:0] ST_ADDR = AW'(BASE + OFF_ST);

  logic [DW-1:0]    cmd_q [NCHAN];
  logic [DW-1:0]    dat_q [NCHAN];
  logic [NCHAN-1:0] en_q, st_q, set_v, clr_v;

  function automatic logic [AW-1:0] cmd_addr(input int c);
    return AW'(BASE + OFF_CMD + 32'(STRIDE * c));
  endfunction
  function automatic logic [AW-1:0] dat_addr(input int c);
    return AW'(BASE + OFF_DAT + 32'(STRIDE * c));
  endfunction

  always_comb begin
    for (int c = 0; c < NCHAN; c++) set_v[c] = snd_wr && (snd_addr == dat_addr(c));
    clr_v = (rcv_wr && rcv_addr == ST_ADDR) ? rcv_wdata[NCHAN-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCHAN; c++) begin
        cmd_q[c] <= '0;
        dat_q[c] <= '0;
      end
      en_q <= '0;
      st_q <= '0;
    end else begin
      for (int c = 0; c < NCHAN; c++) begin
        if (snd_wr && snd_addr == cmd_addr(c)) cmd_q[c] <= snd_wdata;
        if (set_v[c]) dat_q[c] <= snd_wdata;
      end
      // a doorbell in the same cycle as its clear survives
      st_q <= (st_q & ~clr_v) | set_v;
      if (rcv_wr && rcv_addr == EN_ADDR) en_q <= rcv_wdata[NCHAN-1:0];
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    if (rd_addr_a == EN_ADDR) rdata_a = DW'(en_q);
    if (rd_addr_a == ST_ADDR) rdata_a = DW'(st_q);
    if (rd_addr_b == EN_ADDR) rdata_b = DW'(en_q);
    if (rd_addr_b == ST_ADDR) rdata_b = DW'(st_q);
    for (int c = 0; c < NCHAN; c++) begin
      if (rd_addr_a == cmd_addr(c)) rdata_a = cmd_q[c];
      if (rd_addr_a == dat_addr(c)) rdata_a = dat_q[c];
      if (rd_addr_b == cmd_addr(c)) rdata_b = cmd_q[c];
      if (rd_addr_b == dat_addr(c)) rdata_b = dat_q[c];
    end
  end

  assign irq = st_q & en_q;
endmodule

// File: rtl/mbx_locks.sv
module mbx_locks #(
  parameter int NLOCK = 4,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  output logic          a_bit,
  output logic          b_bit
);
  import mbx_pkg::*;
  logic [NLOCK-1:0] held_q, a_hit, b_hit, a_acq, b_acq, rel;

  always_comb begin
    a_bit = 1'b0;
    b_bit = 1'b0;
    for (int i = 0; i < NLOCK; i++) begin
      a_hit[i] = a_addr == AW'(LOCK_BASE + 32'(STRIDE * i));
      b_hit[i] = b_addr == AW'(LOCK_BASE + 32'(STRIDE * i));
      a_acq[i] = a_rd && a_hit[i] && !held_q[i];
      // side A wins a same-cycle race for a free lock
      b_acq[i] = b_rd && b_hit[i] && !held_q[i] && !a_acq[i];
      rel[i]   = (a_wr && a_hit[i]) || (b_wr && b_hit[i]);
      if (a_hit[i]) a_bit = held_q[i];
      if (b_hit[i]) b_bit = held_q[i] || a_acq[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else begin
      for (int i = 0; i < NLOCK; i++) begin
        if (a_acq[i] || b_acq[i]) held_q[i] <= 1'b1;
        else if (rel[i])          held_q[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int NCHAN = 4,
  parameter int NLOCK = 4,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_sel,
  input  logic             a_enable,
  input  logic             a_write,
  input  logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_rdata,
  input  logic             b_sel,
  input  logic             b_enable,
  input  logic             b_write,
  input  logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_wdata,
  output logic [DW-1:0]    b_rdata,
  output logic [NCHAN-1:0] irq_to_a,
  output logic [NCHAN-1:0] irq_to_b
);
  import mbx_pkg::*;
  logic a_wr, a_rd, b_wr, b_rd, a_lk, b_lk;
  logic [DW-1:0] ab_ra, ab_rb, ba_ra, ba_rb;

  assign a_wr = a_sel && a_enable &&  a_write;
  assign a_rd = a_sel && a_enable && !a_write;
  assign b_wr = b_sel && b_enable &&  b_write;
  assign b_rd = b_sel && b_enable && !b_write;

  mbx_dir #(.NCHAN(NCHAN), .DW(DW), .AW(AW), .BASE(A2B_BASE)) u_a2b (
    .clk(clk), .rst_n(rst_n),
    .snd_wr(a_wr), .snd_addr(a_addr), .snd_wdata(a_wdata),
    .rcv_wr(b_wr), .rcv_addr(b_addr), .rcv_wdata(b_wdata),
    .rd_addr_a(a_addr), .rd_addr_b(b_addr),
    .rdata_a(ab_ra), .rdata_b(ab_rb), .irq(irq_to_b));

  mbx_dir #(.NCHAN(NCHAN), .DW(DW), .AW(AW), .BASE(B2A_BASE)) u_b2a (
    .clk(clk), .rst_n(rst_n),
    .snd_wr(b_wr), .snd_addr(b_addr), .snd_wdata(b_wdata),
    .rcv_wr(a_wr), .rcv_addr(a_addr), .rcv_wdata(a_wdata),
    .rd_addr_a(a_addr), .rd_addr_b(b_addr),
    .rdata_a(ba_ra), .rdata_b(ba_rb), .irq(irq_to_a));

  mbx_locks #(.NLOCK(NLOCK), .AW(AW)) u_locks (
    .clk(clk), .rst_n(rst_n),
    .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_addr),
    .b_rd(b_rd), .b_wr(b_wr), .b_addr(b_addr),
    .a_bit(a_lk), .b_bit(b_lk));

  assign a_rdata = ab_ra | ba_ra | DW'(a_lk);
  assign b_rdata = ab_rb | ba_rb | DW'(b_lk);
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int NCHAN = 4,
  parameter int NLOCK = 4,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_sel,
  input logic             a_enable,
  input logic             a_write,
  input logic [AW-1:0]    a_addr,
  input logic [DW-1:0]    a_wdata,
  input logic [DW-1:0]    a_rdata,
  input logic             b_sel,
  input logic             b_enable,
  input logic             b_write,
  input logic [AW-1:0]    b_addr,
  input logic [DW-1:0]    b_wdata,
  input logic [DW-1:0]    b_rdata,
  input logic [NCHAN-1:0] irq_to_a,
  input logic [NCHAN-1:0] irq_to_b
);
  import mbx_pkg::*;
  logic aw, ar, bw, br, a_lock, same_lock;
  logic a2b_ctl_wr, b2a_ctl_wr, a2b_en_wr, b2a_en_wr;
  logic [NCHAN-1:0] a2b_bell, b2a_bell;

  always_comb begin
    aw = a_sel && a_enable && a_write;
    ar = a_sel && a_enable && !a_write;
    bw = b_sel && b_enable && b_write;
    br = b_sel && b_enable && !b_write;
    a2b_en_wr  = bw && b_addr == AW'(A2B_BASE + OFF_EN);
    b2a_en_wr  = aw && a_addr == AW'(B2A_BASE + OFF_EN);
    a2b_ctl_wr = a2b_en_wr || (bw && b_addr == AW'(A2B_BASE + OFF_ST));
    b2a_ctl_wr = b2a_en_wr || (aw && a_addr == AW'(B2A_BASE + OFF_ST));
    a_lock = 1'b0;
    for (int i = 0; i < NLOCK; i++)
      if (a_addr == AW'(LOCK_BASE + 32'(STRIDE * i))) a_lock = 1'b1;
    same_lock = a_lock && a_addr == b_addr;
    for (int c = 0; c < NCHAN; c++) begin
      a2b_bell[c] = aw && a_addr == AW'(A2B_BASE + OFF_DAT + 32'(STRIDE * c));
      b2a_bell[c] = bw && b_addr == AW'(B2A_BASE + OFF_DAT + 32'(STRIDE * c));
    end
  end

  // R1: interrupts are quiet right after reset
  a_r1_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (irq_to_a == '0 && irq_to_b == '0));

  for (genvar c = 0; c < NCHAN; c++) begin : g_irq
    // R3 / R5: an interrupt rises only after a doorbell or an enable write
    a_r3_b_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_to_b[c]) |-> $past(a2b_bell[c] || a2b_en_wr));
    a_r3_a_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_to_a[c]) |-> $past(b2a_bell[c] || b2a_en_wr));
    // R4 / R6: an interrupt falls only after a receiver write to its enable or status
    a_r4_b_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_to_b[c]) |-> $past(a2b_ctl_wr));
    a_r4_a_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_to_a[c]) |-> $past(b2a_ctl_wr));
  end

  // R8: two same-cycle reads of a lock never both win it
  a_r8_lock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (ar && br && same_lock) |-> !(a_rdata[0] == 1'b0 && b_rdata[0] == 1'b0));

  // R7: a lock won by side A reads as held on side A's very next access
  a_r7_lock_held_after_win: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ar && a_lock && a_rdata[0] == 1'b0) && ar && a_addr == $past(a_addr))
      |-> a_rdata[0] == 1'b1);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCHAN(NCHAN), .NLOCK(NLOCK), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_sel = 0, a_enable = 0, a_write = 0, b_sel = 0, b_enable = 0, b_write = 0;
  logic [11:0] a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0, a_rdata, b_rdata;
  logic [3:0] irq_to_a, irq_to_b;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one access per side; both access phases share a clock cycle
  task automatic acc(input logic as, input logic aw, input logic [11:0] aa, input logic [31:0] ad,
                     input logic bs, input logic bw, input logic [11:0] ba, input logic [31:0] bd,
                     output logic [31:0] ra, output logic [31:0] rb);
    @(negedge clk);
    a_sel = as; a_write = aw; a_addr = aa; a_wdata = ad; a_enable = 0;
    b_sel = bs; b_write = bw; b_addr = ba; b_wdata = bd; b_enable = 0;
    @(negedge clk);
    a_enable = as; b_enable = bs;
    #1 ra = a_rdata; rb = b_rdata;
    @(negedge clk);
    a_sel = 0; a_enable = 0; b_sel = 0; b_enable = 0;
  endtask

  task automatic wa(input logic [11:0] ad, input logic [31:0] d);
    logic [31:0] x, y; acc(1, 1, ad, d, 0, 0, 0, 0, x, y);
  endtask
  task automatic wb(input logic [11:0] ad, input logic [31:0] d);
    logic [31:0] x, y; acc(0, 0, 0, 0, 1, 1, ad, d, x, y);
  endtask
  task automatic ra(input logic [11:0] ad, output logic [31:0] d);
    logic [31:0] y; acc(1, 0, ad, 0, 0, 0, 0, 0, d, y);
  endtask
  task automatic rb(input logic [11:0] ad, output logic [31:0] d);
    logic [31:0] x; acc(0, 0, 0, 0, 1, 0, ad, 0, x, d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 irq_to_a", 32'(irq_to_a), 0);
    chk("R1 irq_to_b", 32'(irq_to_b), 0);
    ra(12'h000, v); chk("R1 a2b enable", v, 0);
    rb(12'h02C, v); chk("R1 b2a status", v, 0);
    rb(12'h014, v); chk("R1 a2b data1", v, 0);
    ra(12'h038, v); chk("R1 b2a cmd1", v, 0);
    rb(12'h118, v); chk("R1 lock3 free", v, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    do_reset();
    for (int c = 0; c < 4; c++) begin
      wa(12'(8 + 8*c), 32'hC0DE_0000 + 32'(c));
      wa(12'(12 + 8*c), 32'hDA7A_0000 + 32'(c));
      wb(12'(48 + 8*c), 32'h5EED_0000 + 32'(c));
      wb(12'(52 + 8*c), 32'hFACE_0000 + 32'(c));
    end
    for (int c = 0; c < 4; c++) begin
      rb(12'(8 + 8*c), v);  chk("R2 a2b cmd via B", v, 32'hC0DE_0000 + 32'(c));
      ra(12'(12 + 8*c), v); chk("R2 a2b data via A", v, 32'hDA7A_0000 + 32'(c));
      ra(12'(48 + 8*c), v); chk("R2 b2a cmd via A", v, 32'h5EED_0000 + 32'(c));
      rb(12'(52 + 8*c), v); chk("R2 b2a data via B", v, 32'hFACE_0000 + 32'(c));
    end
    wa(12'h018, 32'h1234_5678);
    rb(12'h018, v); chk("R2 overwrite cmd2", v, 32'h1234_5678);
    rb(12'h01C, v); chk("R2 data2 holds", v, 32'hDA7A_0002);
  endtask

  task automatic t_doorbell();
    logic [31:0] v;
    do_reset();
    wa(12'h018, 32'hAA);
    rb(12'h004, v); chk("R3 cmd write no status", v, 0);
    wa(12'h01C, 32'hBB);
    rb(12'h004, v); chk("R3 data write sets bit2", v, 32'h4);
    wb(12'h04C, 32'h1);
    ra(12'h02C, v); chk("R3 b2a ch3 bit", v, 32'h8);
  endtask

  task automatic t_clear();
    logic [31:0] v, x, y;
    do_reset();
    wa(12'h014, 1); wa(12'h024, 3);
    rb(12'h004, v); chk("R4 two pending", v, 32'hA);
    wb(12'h004, 32'h2);
    rb(12'h004, v); chk("R4 w1c bit1", v, 32'h8);
    wb(12'h004, 32'h0);
    rb(12'h004, v); chk("R4 zero write no change", v, 32'h8);
    acc(1, 1, 12'h00C, 32'h9, 1, 1, 12'h004, 32'h1, x, y);
    rb(12'h004, v); chk("R4 set wins over clear", v, 32'h9);
  endtask

  task automatic t_irq();
    do_reset();
    wa(12'h014, 32'h1);
    chk("R5 masked irq", 32'(irq_to_b), 0);
    wb(12'h000, 32'hF);
    chk("R5 enable all", 32'(irq_to_b), 32'h2);
    wb(12'h000, 32'hD);
    chk("R5 mask ch1", 32'(irq_to_b), 0);
    wb(12'h04C, 32'h7);
    wa(12'h028, 32'h8);
    chk("R5 irq_to_a ch3", 32'(irq_to_a), 32'h8);
    wa(12'h02C, 32'h8);
    chk("R5 clear drops irq_to_a", 32'(irq_to_a), 0);
  endtask

  task automatic t_owner();
    logic [31:0] v;
    do_reset();
    wb(12'h008, 32'hDEAD);
    ra(12'h008, v); chk("R6 B cannot write a2b cmd", v, 0);
    wb(12'h00C, 32'hBEEF);
    rb(12'h004, v); chk("R6 B cannot ring a2b", v, 0);
    wa(12'h000, 32'hF);
    rb(12'h000, v); chk("R6 A cannot write a2b enable", v, 0);
    wa(12'h00C, 32'h1);
    wa(12'h004, 32'h1);
    rb(12'h004, v); chk("R6 A cannot clear a2b status", v, 32'h1);
    wa(12'h034, 32'h5);
    ra(12'h02C, v); chk("R6 A cannot ring b2a", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    do_reset();
    ra(12'h100, v); chk("R7 first read wins", v, 0);
    ra(12'h100, v); chk("R7 second read held", v, 1);
    rb(12'h100, v); chk("R7 other side held", v, 1);
    wb(12'h100, 32'h0);
    ra(12'h100, v); chk("R7 write released", v, 0);
    rb(12'h118, v); chk("R7 lock3 independent", v, 0);
  endtask

  task automatic t_race();
    logic [31:0] x, y, v;
    do_reset();
    acc(1, 0, 12'h108, 0, 1, 0, 12'h108, 0, x, y);
    chk("R8 dual read A wins", x, 0);
    chk("R8 dual read B loses", y, 1);
    acc(1, 1, 12'h108, 32'h5, 1, 0, 12'h108, 0, x, y);
    chk("R8 read vs release held", y, 1);
    ra(12'h108, v); chk("R8 lock freed", v, 0);
    acc(1, 1, 12'h110, 32'h1, 1, 0, 12'h110, 0, x, y);
    chk("R8 read vs write free: reader wins", y, 0);
    ra(12'h110, v); chk("R8 acquire beats release", v, 1);
  endtask

  initial begin
    t_reset();
    t_map();
    t_doorbell();
    t_clear();
    t_irq();
    t_owner();
    t_lock();
    t_race();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule